// File: doc/BRIEF.md
# Banked GPIO Pad Control Registers

This block is a register-mapped controller for the general-purpose pads of a chip. The pads are grouped into banks of eight. Each bank has four 32-bit registers behind a plain single-cycle register bus: a function-select register, a data register, a pull register, and a drive register that holds both the drive strength and the slew rate. The stored fields drive each pad's output enable, output level, pull enable, pull direction, 2-bit drive strength and slew bit. A read of a data register returns the stored level for pins that are outputs and the live pad level for every other pin.

A combinational locator is also part of the block. It turns a flat global pin number into the bank and bit that serve it. Global numbering is split into parts. Each part has a cumulative upper limit, and its banks follow on from the banks of the parts before it. Software or a sequencer uses the locator to find which register address and field belong to a pin. To make a pin an output, the caller first writes the output code into the pin's select field and then writes its data bit.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset every register is zero. Every pad then has output enable low, output level low, pull disabled, drive code 00 and slew bit 0.
- R2: Pin i of a bank has a 4-bit select field at bits 4i+3..4i. Code 0001 is output, code 0000 is input, and codes 0010 to 1111 are alternate functions. The pad's output enable is high only while the field holds 0001. The full 32-bit value reads back unchanged.
- R3: Bit i of the data register drives the pad output level of pin i. Bits 31..8 are not stored. A read of the data register returns, for each pin, the stored bit when the pin's select code is 0001, and the pad input level for every other code.
- R4: Pin i has a 2-bit pull field at bits 2i+1..2i. Code 01 stores pull-down (enable 1, up 0) and code 11 stores pull-up (enable 1, up 1). Codes 00 and 10 both store 00, which disables the pull. Bits 31..16 read as zero.
- R5: In the drive register, pin i has a strength code at bits 2i+1..2i (00 = 1x up to 11 = 4x) and a slew bit at bit 16+i (1 = fast). These drive pad_drive and pad_slew. Bits 31..24 read as zero.
- R6: The word address is {bank, register}: the bank index is in the upper bits and the register is in bits 1..0 (0 select, 1 data, 2 pull, 3 drive). A write takes effect at the clock edge where bus_we is high. bus_rdata presents the addressed word one clock after the address is presented.
- R7: An address whose bank index is NUM_BANKS or above reads as zero, and a write to it changes no register and no pad output.
- R8: The locator sets loc_valid for a pin number below the last part limit. For such a pin, loc_bank is the part's first bank plus (pin − part start)/8, and loc_bit is the low three bits of the pin number. A pin number at or beyond the last part limit gives loc_valid 0, loc_bank 0 and loc_bit 0.
- R9: A write to one bank leaves every other bank's registers and pad outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| bus_addr | input | ADDR_W (5) | Word address {bank, register} |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NPINS (40) | Pad input levels |
| pad_oe | output | NPINS | Pad output enable |
| pad_out | output | NPINS | Pad output level |
| pad_pull_en | output | NPINS | Pull enable |
| pad_pull_up | output | NPINS | Pull direction (1 = up) |
| pad_drive | output | 2*NPINS | Drive strength code, 2 bits per pin |
| pad_slew | output | NPINS | Slew rate (1 = fast) |
| loc_pin | input | LOC_W (6) | Global pin number to locate |
| loc_bank | output | BANK_W (3) | Bank serving the pin |
| loc_bit | output | 3 | Bit of the pin within its bank |
| loc_valid | output | 1 | Pin number is within the mapped range |

## Verification
The hardest case to reach is a data-register read where the answer is split inside one bank. Some pins hold the output code, others hold the input or an alternate code, and a stored data bit disagrees with the pad level. To set this up, the stimulus first writes all ones into a bank's data register while its pins are still inputs, so the stored bits are hidden. It then makes only half the pins outputs and drives pad levels opposite to the stored bits. After that it changes one pin to an alternate code. Each read must therefore take the stored level from some pins and the pad level from the rest.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int PINS_PER_BANK = 8;
    localparam int FUNC_W        = 4;
    localparam int PULL_W        = 2;
    localparam int DRV_W         = 2;
    localparam int SLEW_LSB      = 16;
    localparam int WORD_W        = 32;

    typedef enum logic [1:0] {
        REG_FUNC  = 2'd0,
        REG_DATA  = 2'd1,
        REG_PULL  = 2'd2,
        REG_DRIVE = 2'd3
    } gpio_reg_e;

    localparam logic [FUNC_W-1:0] FUNC_INPUT  = 4'h0;
    localparam logic [FUNC_W-1:0] FUNC_OUTPUT = 4'h1;

    localparam logic [PULL_W-1:0] PULL_OFF  = 2'b00;
    localparam logic [PULL_W-1:0] PULL_DOWN = 2'b01;
    localparam logic [PULL_W-1:0] PULL_UP   = 2'b11;

    // Keep only the two legal pull codes; anything else disables the pull.
    function automatic logic [PULL_W-1:0] pull_filter(input logic [PULL_W-1:0] req);
        if (req == PULL_DOWN || req == PULL_UP) begin
            return req;
        end
        return PULL_OFF;
    endfunction

endpackage

// File: rtl/gpio_pin_locator.sv
module gpio_pin_locator #(
    parameter int NUM_PARTS               = 2,
    parameter int PART_END [NUM_PARTS]    = '{16, 40},
    parameter int NUM_BANKS               = 5,
    parameter int LOC_W                   = 6,
    parameter int BANK_W                  = 3
) (
    input  logic [LOC_W-1:0]  pin_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [2:0]        bit_o,
    output logic              valid_o
);

    always_comb begin
        int   start_pin;
        int   base_bank;
        logic found;
        start_pin = 0;
        base_bank = 0;
        found     = 1'b0;
        bank_o    = '0;
        bit_o     = '0;
        valid_o   = 1'b0;
        for (int p = 0; p < NUM_PARTS; p++) begin
            if (!found && int'(pin_i) < PART_END[p]) begin
                found   = 1'b1;
                valid_o = 1'b1;
                bank_o  = BANK_W'(base_bank + (int'(pin_i) - start_pin) / 8);
                bit_o   = pin_i[2:0];
            end
            base_bank = base_bank + (PART_END[p] - start_pin + 7) / 8;
            start_pin = PART_END[p];
        end
    end

    // R8: a located pin always lands on an existing bank
    always_comb begin
        if (valid_o) begin
            a_r8_bank_in_range: assert (int'(bank_o) < NUM_BANKS)
                else $error("locator bank out of range");
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pad_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  gpio_reg_e                 wr_sel,
    input  logic [WORD_W-1:0]         wr_data,
    input  gpio_reg_e                 rd_sel,
    output logic [WORD_W-1:0]         rd_data,
    input  logic [PINS_PER_BANK-1:0]  pad_in,
    output logic [PINS_PER_BANK-1:0]  pad_oe,
    output logic [PINS_PER_BANK-1:0]  pad_out,
    output logic [PINS_PER_BANK-1:0]  pad_pull_en,
    output logic [PINS_PER_BANK-1:0]  pad_pull_up,
    output logic [2*PINS_PER_BANK-1:0] pad_drive,
    output logic [PINS_PER_BANK-1:0]  pad_slew
);

    localparam int FUNC_BITS = FUNC_W * PINS_PER_BANK;
    localparam int PULL_BITS = PULL_W * PINS_PER_BANK;
    localparam int DRV_BITS  = DRV_W * PINS_PER_BANK;

    logic [FUNC_BITS-1:0]     func_q;
    logic [PINS_PER_BANK-1:0] data_q;
    logic [PULL_BITS-1:0]     pull_q;
    logic [DRV_BITS-1:0]      drv_q;
    logic [PINS_PER_BANK-1:0] slew_q;
    logic [PULL_BITS-1:0]     pull_d;
    logic [PINS_PER_BANK-1:0] data_view;

    always_comb begin
        for (int i = 0; i < PINS_PER_BANK; i++) begin
            pull_d[PULL_W*i +: PULL_W] = pull_filter(wr_data[PULL_W*i +: PULL_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            func_q <= '0;
            data_q <= '0;
            pull_q <= '0;
            drv_q  <= '0;
            slew_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                REG_FUNC:  func_q <= wr_data[FUNC_BITS-1:0];
                REG_DATA:  data_q <= wr_data[PINS_PER_BANK-1:0];
                REG_PULL:  pull_q <= pull_d;
                REG_DRIVE: begin
                    drv_q  <= wr_data[DRV_BITS-1:0];
                    slew_q <= wr_data[SLEW_LSB +: PINS_PER_BANK];
                end
            endcase
        end
    end

    generate
        for (genvar i = 0; i < PINS_PER_BANK; i++) begin : g_pin
            logic is_out;
            assign is_out         = (func_q[FUNC_W*i +: FUNC_W] == FUNC_OUTPUT);
            assign pad_oe[i]      = is_out;
            assign pad_out[i]     = data_q[i];
            assign pad_pull_en[i] = (pull_q[PULL_W*i +: PULL_W] != PULL_OFF);
            assign pad_pull_up[i] = (pull_q[PULL_W*i +: PULL_W] == PULL_UP);
            assign pad_slew[i]    = slew_q[i];
            assign data_view[i]   = is_out ? data_q[i] : pad_in[i];

            // R2: writing the output code enables the pad driver next cycle
            a_r2_oe_on_output_code: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel == REG_FUNC && wr_data[FUNC_W*i +: FUNC_W] == FUNC_OUTPUT)
                |=> pad_oe[i]);
            // R2: any other code leaves the pad undriven
            a_r2_oe_off_other_code: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel == REG_FUNC && wr_data[FUNC_W*i +: FUNC_W] != FUNC_OUTPUT)
                |=> !pad_oe[i]);
            // R4: the reserved pull code disables the pull
            a_r4_reserved_pull_off: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_sel == REG_PULL && wr_data[PULL_W*i +: PULL_W] == 2'b10)
                |=> !pad_pull_en[i]);
        end
    endgenerate

    assign pad_drive = drv_q;

    always_comb begin
        unique case (rd_sel)
            REG_FUNC:  rd_data = func_q;
            REG_DATA:  rd_data = {{(WORD_W-PINS_PER_BANK){1'b0}}, data_view};
            REG_PULL:  rd_data = {{(WORD_W-PULL_BITS){1'b0}}, pull_q};
            REG_DRIVE: rd_data = {{(WORD_W-SLEW_LSB-PINS_PER_BANK){1'b0}}, slew_q,
                                  {(SLEW_LSB-DRV_BITS){1'b0}}, drv_q};
        endcase
    end

    // R3: the output level only moves on a data-register write
    a_r3_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == REG_DATA) |=> $stable(pad_out));
    // R5: drive and slew only move on a drive-register write
    a_r5_drive_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == REG_DRIVE) |=> ($stable(pad_drive) && $stable(pad_slew)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int NUM_BANKS            = 5,
    parameter int NUM_PARTS            = 2,
    parameter int PART_END [NUM_PARTS] = '{16, 40},
    parameter int LOC_W                = 6,
    localparam int NPINS               = NUM_BANKS * PINS_PER_BANK,
    localparam int BANK_W              = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W              = BANK_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [NPINS-1:0]     pad_in,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_pull_en,
    output logic [NPINS-1:0]     pad_pull_up,
    output logic [2*NPINS-1:0]   pad_drive,
    output logic [NPINS-1:0]     pad_slew,
    input  logic [LOC_W-1:0]     loc_pin,
    output logic [BANK_W-1:0]    loc_bank,
    output logic [2:0]           loc_bit,
    output logic                 loc_valid
);

    localparam int PB = PINS_PER_BANK;

    logic [BANK_W-1:0] bank_idx;
    gpio_reg_e         reg_sel;
    logic              bank_hit;
    logic [WORD_W-1:0] bank_rd [NUM_BANKS];
    logic [WORD_W-1:0] rd_mux;

    assign bank_idx = bus_addr[ADDR_W-1:2];
    assign reg_sel  = gpio_reg_e'(bus_addr[1:0]);
    assign bank_hit = (int'(bank_idx) < NUM_BANKS);

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            gpio_bank u_bank (
                .clk         (clk),
                .rst_n       (rst_n),
                .wr_en       (bus_we && (int'(bank_idx) == b)),
                .wr_sel      (reg_sel),
                .wr_data     (bus_wdata),
                .rd_sel      (reg_sel),
                .rd_data     (bank_rd[b]),
                .pad_in      (pad_in[PB*b +: PB]),
                .pad_oe      (pad_oe[PB*b +: PB]),
                .pad_out     (pad_out[PB*b +: PB]),
                .pad_pull_en (pad_pull_en[PB*b +: PB]),
                .pad_pull_up (pad_pull_up[PB*b +: PB]),
                .pad_drive   (pad_drive[2*PB*b +: 2*PB]),
                .pad_slew    (pad_slew[PB*b +: PB])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(bank_idx) == b) begin
                rd_mux = bank_rd[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bank_hit ? rd_mux : '0;
        end
    end

    gpio_pin_locator #(
        .NUM_PARTS (NUM_PARTS),
        .PART_END  (PART_END),
        .NUM_BANKS (NUM_BANKS),
        .LOC_W     (LOC_W),
        .BANK_W    (BANK_W)
    ) u_locator (
        .pin_i   (loc_pin),
        .bank_o  (loc_bank),
        .bit_o   (loc_bit),
        .valid_o (loc_valid)
    );

    // R7: an unmapped address reads as zero on the next cycle
    a_r7_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_hit |=> (bus_rdata == '0));
    // R7: a write to an unmapped address leaves every pad output alone
    a_r7_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bank_hit) |=> ($stable(pad_oe) && $stable(pad_out) &&
            $stable(pad_pull_en) && $stable(pad_pull_up) &&
            $stable(pad_drive) && $stable(pad_slew)));

endmodule

// File: tb/gpio_pad_ctrl_tb.sv
module gpio_pad_ctrl_tb;

    localparam int NB    = 5;
    localparam int NP    = NB * 8;
    localparam int AW    = 5;
    localparam int NVEC  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_oe, pad_out, pad_pull_en, pad_pull_up, pad_slew;
    logic [2*NP-1:0] pad_drive;
    logic [5:0]      loc_pin = '0;
    logic [2:0]      loc_bank;
    logic [2:0]      loc_bit;
    logic            loc_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    gpio_pad_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_we (bus_we), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pad_in (pad_in), .pad_oe (pad_oe), .pad_out (pad_out),
        .pad_pull_en (pad_pull_en), .pad_pull_up (pad_pull_up),
        .pad_drive (pad_drive), .pad_slew (pad_slew),
        .loc_pin (loc_pin), .loc_bank (loc_bank), .loc_bit (loc_bit), .loc_valid (loc_valid)
    );

    // address = bank*4 + register
    localparam logic [AW-1:0] V_ADDR [NVEC] = '{5'd0, 5'd2, 5'd7, 5'd5, 5'd1,
                                               5'd16, 5'd20, 5'd10, 5'd10, 5'd15};
    localparam logic [31:0] V_WDATA [NVEC] = '{32'h1111_1111, 32'h0000_E4E4, 32'hFFFF_FFFF,
                                              32'hFFFF_FFFF, 32'hFFFF_FFA5, 32'hDEAD_BEEF,
                                              32'h1234_5678, 32'h0000_AAAA, 32'h0000_5555,
                                              32'h00A5_1B1B};
    localparam logic [31:0] V_EXP [NVEC] = '{32'h1111_1111, 32'h0000_C4C4, 32'h00FF_FFFF,
                                            32'h0000_0000, 32'h0000_00A5, 32'hDEAD_BEEF,
                                            32'h0000_0000, 32'h0000_0000, 32'h0000_5555,
                                            32'h00A5_1B1B};

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] r;
        logic [NP-1:0]   s_oe, s_out, s_pe, s_pu, s_sl;
        logic [2*NP-1:0] s_dr;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 oe", 80'(pad_oe), 80'(0));
        chk("R1 out", 80'(pad_out), 80'(0));
        chk("R1 pull", 80'({pad_pull_en, pad_pull_up}), 80'(0));
        chk("R1 drive/slew", 80'({pad_drive, pad_slew}) , 80'(0));
        rd(5'd0, r);
        chk("R1 func readback", 80'(r), 80'(0));

        // R6: table of write/readback vectors
        for (int v = 0; v < NVEC; v++) begin
            wr(V_ADDR[v], V_WDATA[v]);
            rd(V_ADDR[v], r);
            chk($sformatf("R6 vector %0d", v), 80'(r), 80'(V_EXP[v]));
        end

        // R2: bank0 all output, bank4 alt codes only, others input
        chk("R2 oe map", 80'(pad_oe), 80'(40'h00_0000_00FF));
        // R3: bank0 data A5 on the pads
        chk("R3 out bank0", 80'(pad_out[7:0]), 80'(8'hA5));
        // R4: bank0 pulls from E4E4 filtered, bank2 all pull-down
        chk("R4 pull_en bank0", 80'(pad_pull_en[7:0]), 80'(8'hAA));
        chk("R4 pull_up bank0", 80'(pad_pull_up[7:0]), 80'(8'h88));
        chk("R4 pull_en bank2", 80'(pad_pull_en[23:16]), 80'(8'hFF));
        chk("R4 pull_up bank2", 80'(pad_pull_up[23:16]), 80'(8'h00));
        // R5: drive and slew
        chk("R5 drive bank1", 80'(pad_drive[31:16]), 80'(16'hFFFF));
        chk("R5 slew bank1", 80'(pad_slew[15:8]), 80'(8'hFF));
        chk("R5 drive bank3", 80'(pad_drive[63:48]), 80'(16'h1B1B));
        chk("R5 slew bank3", 80'(pad_slew[31:24]), 80'(8'hA5));
        // R9: bank1 stored data FF not visible while inputs; bank0 function intact
        chk("R9 bank1 out", 80'(pad_out[15:8]), 80'(8'hFF));
        rd(5'd0, r);
        chk("R9 bank0 func intact", 80'(r), 80'(32'h1111_1111));

        // R3: mixed bank1, pins 0..3 output, 4..7 input
        pad_in[15:8] = 8'h3C;
        wr(5'd4, 32'h0000_1111);
        chk("R2 bank1 oe", 80'(pad_oe[15:8]), 80'(8'h0F));
        rd(5'd5, r);
        chk("R3 mixed read", 80'(r), 80'(32'h3F));
        pad_in[15:8] = 8'hC3;
        rd(5'd5, r);
        chk("R3 live pad read", 80'(r), 80'(32'hCF));
        // R2/R3: pin0 alternate code reads pad level, not driven
        pad_in[15:8] = 8'hC2;
        wr(5'd4, 32'h0000_1112);
        chk("R2 alt code oe", 80'(pad_oe[15:8]), 80'(8'h0E));
        rd(5'd5, r);
        chk("R3 alt code read", 80'(r), 80'(32'hCE));

        // R2/R3: make-output sequence on global pin 19 (bank2 bit3)
        wr(5'd8, 32'h0000_1000);
        wr(5'd9, 32'h0000_0008);
        chk("R2 pin19 oe", 80'(pad_oe[19]), 80'(1'b1));
        chk("R3 pin19 out", 80'(pad_out[19]), 80'(1'b1));

        // R7: unmapped banks 5..7
        s_oe = pad_oe; s_out = pad_out; s_pe = pad_pull_en; s_pu = pad_pull_up;
        s_sl = pad_slew; s_dr = pad_drive;
        wr(5'd29, 32'hFFFF_FFFF);
        wr(5'd28, 32'h1111_1111);
        wr(5'd31, 32'hFFFF_FFFF);
        chk("R7 pads unchanged", 80'({s_oe, s_out}), 80'({pad_oe, pad_out}));
        chk("R7 pulls unchanged", 80'({s_pe, s_pu}), 80'({pad_pull_en, pad_pull_up}));
        chk("R7 drive unchanged", 80'(s_dr), 80'(pad_drive));
        chk("R7 slew unchanged", 80'(s_sl), 80'(pad_slew));
        rd(5'd31, r);
        chk("R7 read zero", 80'(r), 80'(0));

        // R8: locator
        loc_pin = 6'd0;  #1 chk("R8 pin0",  80'({loc_valid, loc_bank, loc_bit}), 80'({1'b1, 3'd0, 3'd0}));
        loc_pin = 6'd15; #1 chk("R8 pin15", 80'({loc_valid, loc_bank, loc_bit}), 80'({1'b1, 3'd1, 3'd7}));
        loc_pin = 6'd16; #1 chk("R8 pin16", 80'({loc_valid, loc_bank, loc_bit}), 80'({1'b1, 3'd2, 3'd0}));
        loc_pin = 6'd39; #1 chk("R8 pin39", 80'({loc_valid, loc_bank, loc_bit}), 80'({1'b1, 3'd4, 3'd7}));
        loc_pin = 6'd40; #1 chk("R8 pin40", 80'({loc_valid, loc_bank, loc_bit}), 80'(0));
        loc_pin = 6'd63; #1 chk("R8 pin63", 80'({loc_valid, loc_bank, loc_bit}), 80'(0));

        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset oe/out", 80'({pad_oe, pad_out}), 80'(0));
        chk("R1 re-reset drive", 80'(pad_drive), 80'(0));
        rst_n = 1'b1;
        rd(5'd16, r);
        chk("R1 re-reset func", 80'(r), 80'(0));

        summary();
    end

endmodule